// File: doc/BRIEF.md
# Base-Limit Memory Protection Checker

The checker decides, for every bus access, whether the address may be used. Software programs a small table of protection regions through a register port. Each region spans an inclusive address range at 32-byte granularity and carries these fields:

- an enable bit
- an execute-never flag
- a two-bit permission code
- a two-bit shareability code
- a three-bit index into a shared table of eight 8-bit memory attribute bytes

The lookup side is purely combinational. It takes an address with privileged, write, instruction-fetch and fault-context qualifiers. In the same cycle it returns allow or fault, the number of the matching region, the region's attribute byte and shareability, and a flag that marks device memory.

Regions are reached indirectly: a selector register names one region, and the base and limit registers read and write that region. A global control register turns the checker on. It also holds two options:

- one keeps checking active while the core runs a hard-fault or non-maskable handler
- one lets privileged accesses that hit no region fall through to a default map

Top module: `prot_check`

## Requirements
- R1: After reset every register reads zero and, with the checker off, every lookup is allowed with region, attribute, shareability and device outputs zero.
- R2: Region bounds are 32-byte aligned. Base register bits [31:5] hold the base and limit register bits [31:5] hold the limit. The low five address bits are not stored, and the range covers the limit block up to its last byte (limit with bits [4:0] all ones). Limit register bit 4 is not stored and reads zero.
- R3: Register offsets:
  - 0: control
  - 1: selector, bits [3:0]
  - 2: base
  - 3: limit
  - 4: attributes for entries 0..3
  - 5: attributes for entries 4..7

  Base and limit accesses reach only the region named by the selector. When the selector is at or above the region count, writes to base and limit change no region and both read zero.
- R4: Attribute entry n sits in the register at offset 4 + n/4, at bits [8*(n mod 4)+7 : 8*(n mod 4)]. The attribute output of a granted access is the entry named by the region's index, which is limit register bits [3:1].
- R5: An address matches a region when the region is enabled (limit bit 0) and the address lies between base and limit inclusive. A single match with sufficient permission is allowed and reports the region number, its attribute byte and its shareability (base bits [4:3]).
- R6: When two or more regions match, the access faults and no region is reported. When no region matches, the access faults unless it is privileged and the default-map option (control bit 2) is set. In that case it is allowed with zero attributes.
- R7: Permission checks on a single match:
  - An instruction fetch from a region with execute-never set (base bit 0) faults.
  - A write to a region whose permission bit 1 (base bit 2, read-only) is set faults.
  - An unprivileged access to a region whose permission bit 0 (base bit 1, unprivileged allowed) is clear faults.

  A faulting access reports the region but zero attributes and shareability.
- R8: While the global enable (control bit 0) is clear, every access is allowed and region, attribute, shareability and device outputs are zero.
- R9: While the fault-context input is high and the keep-active option (control bit 1) is clear, every access is allowed as if the checker were off. With the option set, checks apply as normal.
- R10: The device output is high exactly when an access is granted through a region whose attribute byte has a zero upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| lk_addr | input | 32 | Access address |
| lk_priv | input | 1 | Access is privileged |
| lk_write | input | 1 | Access is a write |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_in_fault | input | 1 | Core is in a hard-fault or non-maskable handler |
| lk_allow | output | 1 | Access permitted |
| lk_fault | output | 1 | Access refused |
| lk_hit | output | 1 | Exactly one region matched while checking was active |
| lk_region | output | IDX_W | Number of the matching region |
| lk_attr | output | 8 | Attribute byte of a granted region access |
| lk_share | output | 2 | Shareability of a granted region access |
| lk_device | output | 1 | Granted access targets device memory |

## Verification
The clocked properties sample the lookup outputs at each rising edge. They therefore assume the lookup inputs are steady around that edge. The bench meets this by changing those inputs only on falling edges.

The register-side property assumes a write strobe lasts one cycle with steady offset and data. The write task holds each write for exactly one full cycle.

The bench programs eight regions with overlapping, disabled and top-of-memory cases. It then sweeps block-edge addresses of every region under all qualifier and control combinations. Expected results come from a model of what was written.

// File: rtl/pchk_pkg.sv
`timescale 1ns/1ps
package pchk_pkg;
   localparam int SEL_W = 4;

   typedef enum logic [2:0] {
      OFF_CTRL  = 3'd0,
      OFF_SEL   = 3'd1,
      OFF_BASE  = 3'd2,
      OFF_LIMIT = 3'd3,
      OFF_ATTRL = 3'd4,
      OFF_ATTRH = 3'd5
   } reg_off_e;

   typedef struct packed {
      logic [26:0] base;
      logic [26:0] lim;
      logic        en;
      logic        xn;
      logic [1:0]  ap;
      logic [1:0]  sh;
      logic [2:0]  aidx;
   } region_t;
endpackage

// File: rtl/pchk_regs.sv
`timescale 1ns/1ps
module pchk_regs
   import pchk_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output logic                ctl_en,
   output logic                ctl_keep,
   output logic                ctl_privdef,
   output region_t [NREG-1:0]  regions,
   output logic [63:0]         attr_bytes
);
   logic [SEL_W-1:0] sel_q;
   logic [31:0]      attr_lo_q, attr_hi_q;
   logic             sel_valid;
   reg_off_e         off;
   region_t          rd_reg;

   assign off        = reg_off_e'(reg_addr);
   assign sel_valid  = ({{(32-SEL_W){1'b0}}, sel_q} < 32'(NREG));
   assign attr_bytes = {attr_hi_q, attr_lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en      <= 1'b0;
         ctl_keep    <= 1'b0;
         ctl_privdef <= 1'b0;
         sel_q       <= '0;
         attr_lo_q   <= '0;
         attr_hi_q   <= '0;
      end else if (wr_en) begin
         case (off)
            OFF_CTRL: begin
               ctl_en      <= wdata[0];
               ctl_keep    <= wdata[1];
               ctl_privdef <= wdata[2];
            end
            OFF_SEL:   sel_q     <= wdata[SEL_W-1:0];
            OFF_ATTRL: attr_lo_q <= wdata;
            OFF_ATTRH: attr_hi_q <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar gi = 0; gi < NREG; gi++) begin : g_region
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regions[gi] <= '0;
         end else if (wr_en && sel_q == SEL_W'(gi)) begin
            if (off == OFF_BASE) begin
               regions[gi].base <= wdata[31:5];
               regions[gi].sh   <= wdata[4:3];
               regions[gi].ap   <= wdata[2:1];
               regions[gi].xn   <= wdata[0];
            end else if (off == OFF_LIMIT) begin
               regions[gi].lim  <= wdata[31:5];
               regions[gi].aidx <= wdata[3:1];
               regions[gi].en   <= wdata[0];
            end
         end
      end
   end

   always_comb begin
      rd_reg = '0;
      for (int i = 0; i < NREG; i++)
         if (sel_q == SEL_W'(i)) rd_reg = regions[i];
   end

   always_comb begin
      rdata = '0;
      case (off)
         OFF_CTRL:  rdata = {29'd0, ctl_privdef, ctl_keep, ctl_en};
         OFF_SEL:   rdata = {{(32-SEL_W){1'b0}}, sel_q};
         OFF_BASE:  rdata = {rd_reg.base, rd_reg.sh, rd_reg.ap, rd_reg.xn};
         OFF_LIMIT: rdata = {rd_reg.lim, 1'b0, rd_reg.aidx, rd_reg.en};
         OFF_ATTRL: rdata = attr_lo_q;
         OFF_ATTRH: rdata = attr_hi_q;
         default:   rdata = '0;
      endcase
   end

   // R3: a region access with the selector out of range leaves the table untouched
   p_sel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (off == OFF_BASE || off == OFF_LIMIT) && !sel_valid) |=> $stable(regions))
      else $error("region table changed through an out-of-range selector");
endmodule

// File: rtl/pchk_match.sv
`timescale 1ns/1ps
module pchk_match
   import pchk_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic [31:0]         addr,
   input  region_t [NREG-1:0]  regions,
   output logic [NREG-1:0]     match
);
   logic [26:0] blk;
   assign blk = addr[31:5];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_cmp
      assign match[gi] = regions[gi].en
                         && (blk >= regions[gi].base)
                         && (blk <= regions[gi].lim);
   end
endmodule

// File: rtl/pchk_resolve.sv
`timescale 1ns/1ps
module pchk_resolve
   import pchk_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic [NREG-1:0]     match,
   input  region_t [NREG-1:0]  regions,
   input  logic [63:0]         attr_bytes,
   input  logic                active,
   input  logic                privdef,
   input  logic                priv,
   input  logic                write,
   input  logic                fetch,
   output logic                allow,
   output logic                fault,
   output logic                hit,
   output logic [IDX_W-1:0]    region,
   output logic [7:0]          attr,
   output logic [1:0]          share,
   output logic                device
);
   logic       one, none, perm_ok, granted;
   logic [IDX_W-1:0] idx;
   region_t    sel;
   logic [7:0] abyte;

   assign one  = $onehot(match);
   assign none = (match == '0);

   always_comb begin
      idx = '0;
      sel = '0;
      for (int i = 0; i < NREG; i++)
         if (match[i]) begin
            idx = IDX_W'(i);
            sel = regions[i];
         end
   end

   assign abyte   = attr_bytes[{sel.aidx, 3'b000} +: 8];
   assign perm_ok = !(fetch && sel.xn) && !(write && sel.ap[1]) && (priv || sel.ap[0]);
   assign granted = active && one && perm_ok;

   assign allow  = !active || granted || (none && priv && privdef);
   assign fault  = !allow;
   assign hit    = active && one;
   assign region = hit ? idx : '0;
   assign attr   = granted ? abyte : 8'h00;
   assign share  = granted ? sel.sh : 2'b00;
   assign device = granted && (abyte[7:4] == 4'h0);
endmodule

// File: rtl/prot_check.sv
`timescale 1ns/1ps
module prot_check
   import pchk_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [31:0]       lk_addr,
   input  logic              lk_priv,
   input  logic              lk_write,
   input  logic              lk_fetch,
   input  logic              lk_in_fault,
   output logic              lk_allow,
   output logic              lk_fault,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_region,
   output logic [7:0]        lk_attr,
   output logic [1:0]        lk_share,
   output logic              lk_device
);
   if (NREG < 1 || NREG > (1 << SEL_W)) begin : g_bad_nreg
      $error("prot_check: NREG must be between 1 and 16");
   end

   logic               ctl_en, ctl_keep, ctl_privdef, active;
   region_t [NREG-1:0] regions;
   logic [63:0]        attr_bytes;
   logic [NREG-1:0]    match;

   pchk_regs #(.NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .reg_addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .ctl_en(ctl_en),
      .ctl_keep(ctl_keep), .ctl_privdef(ctl_privdef),
      .regions(regions), .attr_bytes(attr_bytes)
   );

   pchk_match #(.NREG(NREG)) u_match (
      .addr(lk_addr), .regions(regions), .match(match)
   );

   assign active = ctl_en && (!lk_in_fault || ctl_keep);

   pchk_resolve #(.NREG(NREG), .IDX_W(IDX_W)) u_resolve (
      .match(match), .regions(regions), .attr_bytes(attr_bytes),
      .active(active), .privdef(ctl_privdef), .priv(lk_priv),
      .write(lk_write), .fetch(lk_fetch), .allow(lk_allow),
      .fault(lk_fault), .hit(lk_hit), .region(lk_region),
      .attr(lk_attr), .share(lk_share), .device(lk_device)
   );

   // R8: checker off grants everything with empty attributes
   p_off_allows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> (lk_allow && !lk_hit && lk_attr == 8'h00 && !lk_device))
      else $error("disabled checker did not pass the access");

   // R6: overlapping regions always refuse the access
   p_multi_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $countones(match) > 1) |-> (lk_fault && !lk_hit && lk_attr == 8'h00))
      else $error("multi-region match was not refused");

   // R5: a grant while checking, outside the default map, needs exactly one match
   p_grant_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && lk_allow && !(lk_priv && ctl_privdef)) |-> $onehot(match))
      else $error("grant without a single matching region");

   // R7: fetch from an execute-never region is refused
   p_xn_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_fetch && regions[lk_region].xn) |-> lk_fault)
      else $error("fetch from execute-never region granted");

   // R10: device flag only on granted accesses with a zero upper attribute nibble
   p_device_attr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_device |-> (lk_allow && lk_hit && lk_attr[7:4] == 4'h0))
      else $error("device flag inconsistent with attributes");
endmodule

// File: tb/test_prot_check.sv
`timescale 1ns/1ps
module test_prot_check;
   localparam int NR = 8;
   localparam int IW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] lk_addr = '0;
   logic        lk_priv = 1'b0, lk_write = 1'b0, lk_fetch = 1'b0, lk_in_fault = 1'b0;
   logic        lk_allow, lk_fault, lk_hit, lk_device;
   logic [IW-1:0] lk_region;
   logic [7:0]  lk_attr;
   logic [1:0]  lk_share;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   prot_check #(.NREG(NR)) i_prot_check (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
      .lk_priv(lk_priv), .lk_write(lk_write), .lk_fetch(lk_fetch),
      .lk_in_fault(lk_in_fault), .lk_allow(lk_allow), .lk_fault(lk_fault),
      .lk_hit(lk_hit), .lk_region(lk_region), .lk_attr(lk_attr),
      .lk_share(lk_share), .lk_device(lk_device)
   );

   // model of what software programmed
   logic [31:0] m_base [NR];
   logic [31:0] m_lim  [NR];
   bit          m_en   [NR];
   bit          m_xn   [NR];
   logic [1:0]  m_ap   [NR];
   logic [1:0]  m_sh   [NR];
   logic [2:0]  m_ix   [NR];
   logic [7:0]  m_attr [8];
   bit          c_en, c_keep, c_pdef;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, {32'd0, reg_rdata}, {32'd0, exp});
   endtask

   task automatic set_ctrl(input bit en, input bit keep, input bit pdef);
      c_en = en; c_keep = keep; c_pdef = pdef;
      wr(3'd0, {29'd0, pdef, keep, en});
   endtask

   task automatic program_region(input int k, input logic [31:0] b, input logic [31:0] l,
                                 input bit en, input bit xn, input logic [1:0] ap,
                                 input logic [1:0] sh, input logic [2:0] ix);
      m_base[k] = {b[31:5], 5'd0}; m_lim[k] = {l[31:5], 5'd0};
      m_en[k] = en; m_xn[k] = xn; m_ap[k] = ap; m_sh[k] = sh; m_ix[k] = ix;
      wr(3'd1, 32'(k));
      wr(3'd2, {b[31:5], sh, ap, xn});
      wr(3'd3, {l[31:5], 1'b1, ix, en});   // bit 4 set on purpose: must not stick
   endtask

   task automatic lookup(input logic [31:0] a, input bit pv, input bit w, input bit f, input bit inf);
      bit act, one, none, pok, grant, allow_e;
      int nm, k1;
      string tag;
      logic [7:0] ab;
      logic [63:0] exp_v, act_v;
      act = c_en && (!inf || c_keep);
      nm = 0; k1 = 0;
      for (int k = 0; k < NR; k++)
         if (m_en[k] && a[31:5] >= m_base[k][31:5] && a[31:5] <= m_lim[k][31:5]) begin
            nm++; k1 = k;
         end
      one = (nm == 1); none = (nm == 0);
      pok = one && !(f && m_xn[k1]) && !(w && m_ap[k1][1]) && (pv || m_ap[k1][0]);
      grant = act && pok;
      ab = m_attr[m_ix[k1]];
      allow_e = !act || grant || (none && pv && c_pdef);
      if (!c_en)              tag = "R8";
      else if (!act)          tag = "R9";
      else if (!one)          tag = "R6";
      else if (!pok)          tag = "R7";
      else if (ab[7:4] == 0)  tag = "R10";
      else                    tag = "R5";
      exp_v = {45'd0, allow_e, !allow_e, act && one, (act && one) ? 3'(k1) : 3'd0,
               grant ? ab : 8'h00, grant ? m_sh[k1] : 2'b00, grant && ab[7:4] == 4'h0};
      @(negedge clk);
      lk_addr = a; lk_priv = pv; lk_write = w; lk_fetch = f; lk_in_fault = inf;
      #1;
      act_v = {45'd0, lk_allow, lk_fault, lk_hit, lk_region, lk_attr, lk_share, lk_device};
      check(tag, act_v, exp_v);
   endtask

   task automatic sweep_all();
      logic [31:0] pts[$];
      pts.push_back(32'h0);
      for (int k = 0; k < NR; k++) begin
         pts.push_back(m_base[k] - 32'd1);
         pts.push_back(m_base[k]);
         pts.push_back(m_base[k] + 32'h11);
         pts.push_back(m_lim[k] | 32'h1F);
         pts.push_back((m_lim[k] | 32'h1F) + 32'd1);
      end
      foreach (pts[p])
         for (int q = 0; q < 16; q++)
            lookup(pts[p], q[0], q[1], q[2], q[3]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NR; k++) begin
         m_base[k] = '0; m_lim[k] = '0; m_en[k] = 0; m_xn[k] = 0;
         m_ap[k] = '0; m_sh[k] = '0; m_ix[k] = '0;
      end
      for (int k = 0; k < 8; k++) m_attr[k] = '0;
      c_en = 0; c_keep = 0; c_pdef = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) rd_check("R1", 3'(a), 32'd0);
      lookup(32'h0000_1234, 0, 1, 1, 0);
      lookup(32'hFFFF_FFFF, 1, 0, 0, 0);

      // R4: attribute table layout
      m_attr[0] = 8'h44; m_attr[1] = 8'h11; m_attr[2] = 8'hAA; m_attr[3] = 8'hFF;
      m_attr[4] = 8'h33; m_attr[5] = 8'h04; m_attr[6] = 8'h22; m_attr[7] = 8'h0C;
      wr(3'd4, 32'hFFAA_1144);
      wr(3'd5, 32'h0C22_0433);
      rd_check("R4", 3'd4, 32'hFFAA_1144);
      rd_check("R4", 3'd5, 32'h0C22_0433);

      // region table: overlap (2,3), disabled (4), top of memory (7)
      program_region(0, 32'h0000_1000, 32'h0000_1FE0, 1, 0, 2'b01, 2'b01, 3'd0);
      program_region(1, 32'h0000_2000, 32'h0000_2FE0, 1, 1, 2'b11, 2'b10, 3'd5);
      program_region(2, 32'h0000_3000, 32'h0000_3FE0, 1, 0, 2'b00, 2'b11, 3'd3);
      program_region(3, 32'h0000_3800, 32'h0000_3820, 1, 0, 2'b01, 2'b00, 3'd1);
      program_region(4, 32'h0000_5000, 32'h0000_5FE0, 0, 0, 2'b01, 2'b01, 3'd2);
      program_region(5, 32'h0001_0000, 32'h0001_0000, 1, 0, 2'b01, 2'b10, 3'd6);
      program_region(6, 32'h8000_0000, 32'h8000_FFE0, 1, 1, 2'b01, 2'b01, 3'd4);
      program_region(7, 32'hFFFF_FFE0, 32'hFFFF_FFE0, 1, 0, 2'b10, 2'b01, 3'd7);

      // R2: readback shows aligned bounds, limit bit 4 reads zero
      wr(3'd1, 32'd1);
      rd_check("R2", 3'd2, 32'h0000_2000 | {27'd0, 2'b10, 2'b11, 1'b1});
      rd_check("R2", 3'd3, 32'h0000_2FE0 | {28'd0, 3'd5, 1'b1});
      rd_check("R3", 3'd1, 32'd1);

      // R3: out-of-range selector changes nothing and reads zero
      wr(3'd1, 32'd9);
      wr(3'd2, 32'h0000_0000);
      wr(3'd3, 32'hFFFF_FFE1);
      rd_check("R3", 3'd2, 32'd0);
      rd_check("R3", 3'd3, 32'd0);
      wr(3'd1, 32'd7);
      rd_check("R3", 3'd2, 32'hFFFF_FFE0 | {27'd0, 2'b01, 2'b10, 1'b0});

      // sweep all control settings (R5..R10)
      for (int c = 0; c < 8; c++) begin
         set_ctrl(c[0], c[1], c[2]);
         rd_check("R1", 3'd0, 32'(c));
         sweep_all();
      end
      // after the sweep with the checker on, region 7 still intact (R3)
      set_ctrl(1, 0, 0);
      lookup(32'hFFFF_FFF0, 1, 0, 0, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule